// File: doc/BRIEF.md
# Display Interrupt Status Unit

This block gathers the event pulses of a multi-channel display controller and turns them into sticky status bits, a single level-sensitive interrupt line and an interrupt-ID register. The DMA and timing logic around it report start of frame, end of frame, branch, bus error, frame completion and a handful of auxiliary conditions. The unit records each one, decides whether software should be told, and remembers which channel's frame ID caused the first notification.

Software reaches two control registers (the mask bits plus the panel enable and the stop-after-frame request), two status registers and the ID register through a small register port. Status bits are cleared by writing ones. When the line is already raised, a new unmasked event does not overwrite the ID. It sets a "further interrupt" flag instead, so the handler knows that more than one cause is waiting.

Top module: `disp_irq_status`

## Requirements
- R1: After reset all five registers read zero, `irq` is low and `panel_en` is low. Register select codes are 0 for control A, 1 for control B, 2 for status A, 3 for status B and 4 for the ID register. Other codes read zero.
- R2: For channel 0, start of frame sets status A bit 1, end of frame sets bit 8 and branch sets bit 9. Start and end of frame take effect only when that channel's `sof_en`/`eof_en` bit is high.
- R3: For a channel ch from 1 to NCH-1, start of frame sets status B bit ch-1, end of frame sets bit ch+7 and branch sets bit ch+15. The same enable gating applies, and bits 31:22 of status B stay zero.
- R4: A bus error sets status A bit 2 and writes `ev_ber_ch` into bits 30:28. No mask applies to it, and it counts as an unmasked event of that channel.
- R5: When `irq` is low and one or more unmasked channel events arrive in a cycle, the ID register takes the frame ID of the lowest-numbered such channel.
- R6: When `irq` is high, an unmasked channel event sets status A bit 10 and leaves the ID register unchanged.
- R7: A masked event still sets its status bit, but it neither loads the ID nor sets bit 10. Channel 0 uses control A bits 4 (start), 6 (end) and 20 (branch). Channel ch uses control B bits ch-1, ch+7 and ch+15.
- R8: A write to status A clears the ones written within bits 11:0. Writing a one to bit 2 also clears bits 30:28. An event in the same cycle wins over the clear.
- R9: A write to status B clears the ones written within mask 0x3E3F3F, so bit 16 (branch of channel 1) is not cleared by a write.
- R10: `irq` is a register that rises or falls one cycle after the status or mask registers change. Its sources are status A bits 0, 1, 4, 5, 6, 7, 8, 9, 11 and 12, masked respectively by control A bits 3, 4, 5, control B bit 24, and control A bits 21, 11, 6, 20, 23, 24. Every status B bit n is masked by control B bit n.
- R11: A write to control A that changes bit 0 from 1 to 0 sets status A bit 7.
- R12: `frame_done` while control A bits 10 and 0 are both set clears control A bit 0 and sets status A bit 1's neighbour, bit 0. Otherwise `frame_done` has no effect.
- R13: `ev_aux` bits 0 to 4 set status A bits 4, 5, 6, 11 and 12. They neither load the ID nor set bit 10.
- R14: Control A keeps only bits under 0x07FFFFFF and control B only bits under 0x3F3F3F3F. Writes to the ID register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | AW | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel` (combinational) |
| ev_sof | input | NCH | Start-of-frame pulse per channel |
| ev_eof | input | NCH | End-of-frame pulse per channel |
| ev_bs | input | NCH | Branch pulse per channel |
| sof_en | input | NCH | Start-of-frame report enable from each channel's command word |
| eof_en | input | NCH | End-of-frame report enable from each channel's command word |
| ev_ber | input | 1 | Bus error pulse |
| ev_ber_ch | input | 3 | Channel of the bus error |
| ev_aux | input | 5 | Auxiliary condition pulses |
| frame_done | input | 1 | End of the displayed frame |
| frame_id | input | NCH*IDW | Current frame ID of each channel, channel 0 in the low bits |
| irq | output | 1 | Registered interrupt line |
| panel_en | output | 1 | Control A bit 0 |

## Verification
A software clear of status A and a new event for the same bit can land in one cycle. The bench drives a write-one-to-clear of bits 1 and 2 in the same cycle as a start-of-frame pulse on channel 0, and expects bit 1 to survive while bit 2 and the channel field drop. Channel events of several channels can also coincide. The bench pulses three channels at once and judges that the lowest one supplies the ID. It then fires an event after `irq` has risen and expects bit 10 with the ID held.

// File: rtl/disp_irq_status.sv
module disp_irq_status #(
  parameter int NCH = 7,
  parameter int IDW = 32,
  parameter int AW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NCH-1:0]     ev_sof,
  input  logic [NCH-1:0]     ev_eof,
  input  logic [NCH-1:0]     ev_bs,
  input  logic [NCH-1:0]     sof_en,
  input  logic [NCH-1:0]     eof_en,
  input  logic               ev_ber,
  input  logic [2:0]         ev_ber_ch,
  input  logic [4:0]         ev_aux,
  input  logic               frame_done,
  input  logic [NCH*IDW-1:0] frame_id,
  output logic               irq,
  output logic               panel_en
);

  localparam int CHW = 3;
  localparam logic [AW-1:0] SEL_CA = AW'(0);
  localparam logic [AW-1:0] SEL_CB = AW'(1);
  localparam logic [AW-1:0] SEL_SA = AW'(2);
  localparam logic [AW-1:0] SEL_SB = AW'(3);
  localparam logic [AW-1:0] SEL_ID = AW'(4);
  localparam logic [31:0] CA_KEEP = 32'h07FF_FFFF;
  localparam logic [31:0] CB_KEEP = 32'h3F3F_3F3F;
  localparam logic [31:0] SA_W1C  = 32'h0000_0FFF;
  localparam logic [31:0] SB_W1C  = 32'h003E_3F3F;

  logic [31:0]    ca_q, cb_q, sa_q, sb_q;
  logic [31:0]    ca_d, sa_d, sb_d;
  logic [IDW-1:0] id_q;
  logic           irq_q;
  logic [31:0]    sa_set, sb_set;
  logic [NCH-1:0] hit;
  logic [CHW-1:0] win_ch;
  logic           any_hit;
  logic [9:0]     sa_live;
  logic           irq_d;

  wire wr_ca  = reg_wr && (reg_sel == SEL_CA);
  wire wr_cb  = reg_wr && (reg_sel == SEL_CB);
  wire wr_sa  = reg_wr && (reg_sel == SEL_SA);
  wire wr_sb  = reg_wr && (reg_sel == SEL_SB);
  wire qd_ev  = wr_ca && ca_q[0] && !reg_wdata[0];
  wire ldd_ev = frame_done && ca_q[10] && ca_q[0];

  always_comb begin
    sa_set = '0;
    sb_set = '0;
    hit    = '0;
    sa_set[1] = ev_sof[0] & sof_en[0];
    sa_set[8] = ev_eof[0] & eof_en[0];
    sa_set[9] = ev_bs[0];
    hit[0] = (sa_set[1] & ~ca_q[4]) | (sa_set[8] & ~ca_q[6]) | (sa_set[9] & ~ca_q[20]);
    for (int ch = 1; ch < NCH; ch++) begin
      sb_set[ch-1]  = ev_sof[ch] & sof_en[ch];
      sb_set[ch+7]  = ev_eof[ch] & eof_en[ch];
      sb_set[ch+15] = ev_bs[ch];
      hit[ch] = (sb_set[ch-1] & ~cb_q[ch-1]) | (sb_set[ch+7] & ~cb_q[ch+7]) |
                (sb_set[ch+15] & ~cb_q[ch+15]);
    end
    for (int ch = 0; ch < NCH; ch++)
      if (ev_ber && ev_ber_ch == CHW'(ch)) hit[ch] = 1'b1;
    sa_set[4]  = ev_aux[0];
    sa_set[5]  = ev_aux[1];
    sa_set[6]  = ev_aux[2];
    sa_set[11] = ev_aux[3];
    sa_set[12] = ev_aux[4];
  end

  always_comb begin
    win_ch = '0;
    for (int ch = NCH - 1; ch >= 0; ch--)
      if (hit[ch]) win_ch = CHW'(ch);
  end
  assign any_hit = |hit;

  assign sa_live = {sa_q[12] & ~ca_q[24], sa_q[11] & ~ca_q[23], sa_q[9] & ~ca_q[20],
                    sa_q[8] & ~ca_q[6],   sa_q[7] & ~ca_q[11],  sa_q[6] & ~ca_q[21],
                    sa_q[5] & ~cb_q[24],  sa_q[4] & ~ca_q[5],   sa_q[1] & ~ca_q[4],
                    sa_q[0] & ~ca_q[3]};
  assign irq_d = (|sa_live) | (|(sb_q & ~cb_q));

  always_comb begin
    ca_d = ca_q;
    if (wr_ca) ca_d = reg_wdata & CA_KEEP;
    else if (ldd_ev) ca_d[0] = 1'b0;

    sa_d = sa_q;
    if (wr_sa) begin
      sa_d = sa_q & ~(reg_wdata & SA_W1C);
      if (reg_wdata[2]) sa_d[30:28] = '0;
    end
    sa_d = sa_d | sa_set;
    if (ev_ber) begin
      sa_d[2]     = 1'b1;
      sa_d[30:28] = ev_ber_ch;
    end
    if (qd_ev) sa_d[7] = 1'b1;
    if (ldd_ev) sa_d[0] = 1'b1;
    if (any_hit && irq_q) sa_d[10] = 1'b1;

    sb_d = sb_q;
    if (wr_sb) sb_d = sb_q & ~(reg_wdata & SB_W1C);
    sb_d = sb_d | sb_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_q  <= '0;
      cb_q  <= '0;
      sa_q  <= '0;
      sb_q  <= '0;
      id_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      ca_q  <= ca_d;
      if (wr_cb) cb_q <= reg_wdata & CB_KEEP;
      sa_q  <= sa_d;
      sb_q  <= sb_d;
      irq_q <= irq_d;
      if (any_hit && !irq_q) id_q <= frame_id[int'(win_ch)*IDW +: IDW];
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CA:  reg_rdata = ca_q;
      SEL_CB:  reg_rdata = cb_q;
      SEL_SA:  reg_rdata = sa_q;
      SEL_SB:  reg_rdata = sb_q;
      SEL_ID:  reg_rdata = 32'(id_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq      = irq_q;
  assign panel_en = ca_q[0];

  p_ber_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ber |=> (sa_q[2] && sa_q[30:28] == $past(ev_ber_ch)));
  p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> $stable(id_q));
  p_further_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && irq_q) |=> sa_q[10]);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_q == 32'h0 && sb_q == 32'h0) |=> !irq_q);
  p_qd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    qd_ev |=> sa_q[7]);
  p_ldd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ldd_ev && !wr_ca) |=> (!ca_q[0] && sa_q[0]));
  p_sb_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sb_q[31:22] == 10'h0);

endmodule

// File: tb/disp_irq_status_test.sv
`timescale 1ns/1ps
module disp_irq_status_test;
  localparam int NCH = 7;
  localparam int IDW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [2:0] reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NCH-1:0] ev_sof, ev_eof, ev_bs, sof_en, eof_en;
  logic ev_ber;
  logic [2:0] ev_ber_ch;
  logic [4:0] ev_aux;
  logic frame_done;
  logic [NCH*IDW-1:0] frame_id;
  logic irq, panel_en;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  disp_irq_status #(.NCH(NCH), .IDW(IDW), .AW(3)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sof(ev_sof),
    .ev_eof(ev_eof), .ev_bs(ev_bs), .sof_en(sof_en), .eof_en(eof_en),
    .ev_ber(ev_ber), .ev_ber_ch(ev_ber_ch), .ev_aux(ev_aux),
    .frame_done(frame_done), .frame_id(frame_id), .irq(irq), .panel_en(panel_en));

  function automatic logic [31:0] fid(int k);
    return 32'hF1D0_0000 | 32'(k * 17 + 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_ev();
    ev_sof = '0; ev_eof = '0; ev_bs = '0; ev_ber = 1'b0; ev_ber_ch = '0;
    ev_aux = '0; frame_done = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    clr_ev();
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clr_ev(); sof_en = '0; eof_en = '0;
    reg_sel = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), d);
      chk("R1 register after reset", d, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 panel_en after reset", 32'(panel_en), 32'h0);
  endtask

  task automatic t_ch0();
    logic [31:0] d;
    do_reset();
    sof_en[0] = 1'b1;
    ev_sof[0] = 1'b1; ev_eof[0] = 1'b1;
    step();
    rd(2, d); chk("R2 channel0 sof set, eof gated", d, 32'h2);
    rd(4, d); chk("R5 id loaded from channel0", d, fid(0));
    chk("R10 irq not yet high", 32'(irq), 32'h0);
    step();
    chk("R10 irq high one cycle later", 32'(irq), 32'h1);
    ev_bs[0] = 1'b1;
    step();
    rd(2, d); chk("R6 branch plus further flag", d, 32'h602);
    rd(4, d); chk("R6 id held while irq high", d, fid(0));
    wr(2, 32'hFFF);
    rd(2, d); chk("R8 status A cleared", d, 32'h0);
    step();
    chk("R10 irq falls after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_chn();
    logic [31:0] d;
    do_reset();
    sof_en = '1; eof_en = '1;
    ev_sof[3] = 1'b1; ev_eof[3] = 1'b1; ev_bs[3] = 1'b1;
    ev_bs[2] = 1'b1; ev_sof[5] = 1'b1;
    step();
    rd(3, d); chk("R3 status B channel bits", d, 32'h0006_0414);
    rd(4, d); chk("R5 lowest channel wins id", d, fid(2));
    step();
    eof_en[4] = 1'b0;
    ev_eof[4] = 1'b1;
    step();
    rd(3, d); chk("R3 gated eof leaves status B", d, 32'h0006_0414);
    rd(2, d); chk("R3 gated eof sets no further flag", d, 32'h0);
  endtask

  task automatic t_sb_clear();
    logic [31:0] d;
    do_reset();
    sof_en[1] = 1'b1;
    ev_bs[1] = 1'b1; ev_bs[6] = 1'b1; ev_sof[1] = 1'b1;
    step();
    rd(3, d); chk("R3 channels 1 and 6", d, 32'h0021_0001);
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk("R9 bit16 survives write", d, 32'h0001_0000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(0, 32'h10);
    sof_en[0] = 1'b1; ev_sof[0] = 1'b1;
    step();
    rd(2, d); chk("R7 masked sof still recorded", d, 32'h2);
    rd(4, d); chk("R7 masked sof leaves id", d, 32'h0);
    step(); step();
    chk("R7 masked sof keeps irq low", 32'(irq), 32'h0);
    wr(1, 32'h200);
    eof_en[2] = 1'b1; ev_eof[2] = 1'b1;
    step();
    rd(3, d); chk("R7 masked channel2 eof recorded", d, 32'h200);
    rd(4, d); chk("R7 masked channel2 eof leaves id", d, 32'h0);
    step();
    chk("R7 irq still low", 32'(irq), 32'h0);
    wr(0, 32'h0);
    chk("R10 irq not yet after unmask", 32'(irq), 32'h0);
    step();
    chk("R10 irq rises after unmask", 32'(irq), 32'h1);
  endtask

  task automatic t_ber();
    logic [31:0] d;
    do_reset();
    ev_ber = 1'b1; ev_ber_ch = 3'd5;
    step();
    rd(2, d); chk("R4 bus error bit and field", d, 32'h5000_0004);
    rd(4, d); chk("R4 bus error loads id", d, fid(5));
    step();
    chk("R10 bus error not an irq source", 32'(irq), 32'h0);
    sof_en[0] = 1'b1; ev_sof[0] = 1'b1;
    reg_wr = 1'b1; reg_sel = 3'd2; reg_wdata = 32'h6;
    step();
    rd(2, d); chk("R8 event wins over clear, field cleared", d, 32'h2);
    rd(4, d); chk("R5 id from channel0", d, fid(0));
    step();
    ev_ber = 1'b1; ev_ber_ch = 3'd1;
    step();
    rd(2, d); chk("R6 bus error while irq high", d, 32'h1000_0406);
    rd(4, d); chk("R6 id held", d, fid(0));
  endtask

  task automatic t_aux();
    logic [31:0] d;
    do_reset();
    wr(0, 32'h01A0_0020);
    wr(1, 32'h0100_0000);
    ev_aux = 5'h1F;
    step();
    rd(2, d); chk("R13 aux bits", d, 32'h1870);
    rd(4, d); chk("R13 aux leaves id", d, 32'h0);
    step(); step();
    chk("R13 masked aux irq low", 32'(irq), 32'h0);
    wr(0, 32'h0180_0020);
    step();
    chk("R10 unmasked overrun raises irq", 32'(irq), 32'h1);
  endtask

  task automatic t_qd();
    logic [31:0] d;
    do_reset();
    wr(0, 32'h1);
    rd(2, d); chk("R11 enabling sets nothing", d, 32'h0);
    chk("R11 panel_en high", 32'(panel_en), 32'h1);
    wr(0, 32'h0);
    rd(2, d); chk("R11 quick disable done", d, 32'h80);
    wr(2, 32'h80);
    wr(0, 32'h0);
    rd(2, d); chk("R11 no flag when already off", d, 32'h0);
  endtask

  task automatic t_ldd();
    logic [31:0] d;
    do_reset();
    wr(0, 32'h401);
    frame_done = 1'b1;
    step();
    rd(0, d); chk("R12 enable dropped", d, 32'h400);
    rd(2, d); chk("R12 last frame done", d, 32'h1);
    wr(2, 32'h1);
    frame_done = 1'b1;
    step();
    rd(2, d); chk("R12 no effect when disabled", d, 32'h0);
    do_reset();
    wr(0, 32'h1);
    frame_done = 1'b1;
    step();
    rd(0, d); chk("R12 no stop request keeps enable", d, 32'h1);
    rd(2, d); chk("R12 no stop request no status", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R14 control A keep mask", d, 32'h07FF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R14 control B keep mask", d, 32'h3F3F_3F3F);
    wr(4, 32'h1234_5678);
    rd(4, d); chk("R14 id read-only", d, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) frame_id[k*IDW +: IDW] = fid(k);
    t_reset();
    t_ch0();
    t_chn();
    t_sb_clear();
    t_mask();
    t_ber();
    t_aux();
    t_qd();
    t_ldd();
    t_regs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule